// File: doc/BRIEF.md
# Dual Down-Counter System Timer

This peripheral holds two independent 32-bit down counters behind one word-addressed register window. Software programs each counter through a six-word bank: a load word, a background load word, a control word, a raw expiry flag and two read-only views, the live count and the masked flag. The first bank takes word addresses 0 to 5 and the second takes 6 to 11. Any higher address reads zero and ignores writes.

A counter started through its control word copies the load word and counts down by one each clock. When it reaches zero it sets its raw flag. In periodic mode it then reloads from the load word. In one-shot mode it halts at zero. Each counter drives its own interrupt line, which is the raw flag gated by the control word's interrupt-enable bit. The background load word lets software stage a new period without disturbing the count in progress.

Top module: `dual_down_timer`

## Requirements
- R1: A synchronous active-high reset clears every register, the count and the run state of both timers, so every address reads zero and both irq bits are low.
- R2: Word addresses 0..5 select timer 0 and 6..11 select timer 1, with in-bank offsets 0 count, 1 load, 2 background load, 3 control, 4 raw flag, 5 masked flag. Addresses 12 and above read 0 and writes to them change nothing.
- R3: Control bit 0 is enable, bit 1 is one-shot and bit 2 is interrupt enable, and the control word reads back in bits 2:0. A control write with bit 0 set copies the load word into the count and starts counting. A control write with bit 0 clear stops counting and holds the count.
- R4: A running counter whose count is nonzero decreases by exactly one on each clock.
- R5: A running counter at zero sets its raw flag on the next clock. In periodic mode it reloads from the load word on that same clock, so the period is load+1 clocks.
- R6: In one-shot mode a running counter at zero stops and keeps reading 0 until its control or load word is written again.
- R7: A write to the load word while control bit 0 is set also copies the new value into the count and restarts counting. With bit 0 clear, the write only stores the value.
- R8: A write to the background load word stores the value in both the background and the load words and leaves the count running undisturbed.
- R9: Writing 1 in bit 0 of the raw flag word clears the flag. Writing 0 there has no effect. If an expiry occurs on the same clock as the clear, the flag stays set.
- R10: The masked flag word (bit 0) and the timer's irq bit both equal the raw flag AND control bit 2, and both follow every register write.
- R11: Writes to the count word and the masked flag word are ignored.
- R12: The two timers are independent, so an access to one bank never alters the other timer's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address into the register window |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq | output | 2 | Per-timer interrupt, bit i for timer i |

## Verification
A wrong count or run state shows at once in the count word. One clock later it also shows at the irq line and the flag words, because expiry is judged on the registered count. A lost reload or a one-shot that fails to stop makes the count diverge from the reference model on the clock after the counter hits zero. A misrouted bank write shows up as a change in the other timer's words. The bench compares the read data and both irq bits against a behavioural model on every clock while it sweeps addresses, so such faults appear within the same or the next cycle.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    localparam int NUM_TIMERS = 2;
    localparam int BANK_WORDS = 6;
    localparam int WINDOW_WORDS = NUM_TIMERS * BANK_WORDS;
    localparam int OFF_W = 3;

    typedef enum logic [OFF_W-1:0] {
        OFF_VALUE  = 3'd0,
        OFF_LOAD   = 3'd1,
        OFF_BGLOAD = 3'd2,
        OFF_CTRL   = 3'd3,
        OFF_RAW    = 3'd4,
        OFF_MASKED = 3'd5
    } reg_off_e;

    typedef struct packed {
        logic irq_en;
        logic one_shot;
        logic enable;
    } ctrl_t;

    function automatic ctrl_t to_ctrl(input logic [2:0] bits);
        return ctrl_t'(bits);
    endfunction

endpackage

// File: rtl/dtimer_decode.sv
module dtimer_decode
    import dtimer_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_TIMERS-1:0] sel,
    output reg_off_e              off
);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * BANK_WORDS);
        localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'((i + 1) * BANK_WORDS);
        assign sel[i] = (addr >= BASE) && (addr < LIMIT);
    end

    always_comb begin
        logic [ADDR_W-1:0] diff;
        diff = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (sel[i]) diff = addr - ADDR_W'(i * BANK_WORDS);
        end
        off = reg_off_e'(diff[OFF_W-1:0]);
    end

endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
    import dtimer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_off_e          off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] load,
    output ctrl_t             ctrl,
    output logic              raw,
    output logic              running,
    output logic              irq
);

    logic [DATA_W-1:0] bg_q;
    logic              expire;

    assign expire = running && (count == '0);
    assign irq    = raw && ctrl.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            load    <= '0;
            bg_q    <= '0;
            ctrl    <= '0;
            raw     <= 1'b0;
            running <= 1'b0;
        end else begin
            // free-running behaviour first; register writes below override it
            if (running) begin
                if (expire) begin
                    if (ctrl.one_shot) running <= 1'b0;
                    else count <= load;
                end else begin
                    count <= count - DATA_W'(1);
                end
            end

            if (wr && off == OFF_RAW && wdata[0]) raw <= 1'b0;
            if (expire) raw <= 1'b1;

            if (wr) begin
                case (off)
                    OFF_CTRL: begin
                        ctrl <= to_ctrl(wdata[2:0]);
                        if (wdata[0]) begin
                            count   <= load;
                            running <= 1'b1;
                        end else begin
                            running <= 1'b0;
                        end
                    end
                    OFF_LOAD: begin
                        load <= wdata;
                        if (ctrl.enable) begin
                            count   <= wdata;
                            running <= 1'b1;
                        end
                    end
                    OFF_BGLOAD: begin
                        bg_q <= wdata;
                        load <= wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (off)
            OFF_VALUE:  rd_word = count;
            OFF_LOAD:   rd_word = load;
            OFF_BGLOAD: rd_word = bg_q;
            OFF_CTRL:   rd_word[2:0] = ctrl;
            OFF_RAW:    rd_word[0] = raw;
            OFF_MASKED: rd_word[0] = irq;
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import dtimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);

    logic [NUM_TIMERS-1:0]             sel;
    reg_off_e                          off;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] ch_rd;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] ch_count;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] ch_load;
    logic [NUM_TIMERS-1:0]             ch_run;
    logic [NUM_TIMERS-1:0]             ch_raw;
    logic [NUM_TIMERS-1:0]             ch_oneshot;
    logic [NUM_TIMERS-1:0]             ch_ie;

    dtimer_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .off  (off)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
        ctrl_t ctrl_i;

        dtimer_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr      (bus_we && sel[i]),
            .off     (off),
            .wdata   (bus_wdata),
            .rd_word (ch_rd[i]),
            .count   (ch_count[i]),
            .load    (ch_load[i]),
            .ctrl    (ctrl_i),
            .raw     (ch_raw[i]),
            .running (ch_run[i]),
            .irq     (irq[i])
        );

        assign ch_oneshot[i] = ctrl_i.one_shot;
        assign ch_ie[i]      = ctrl_i.irq_en;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (sel[i]) bus_rdata = ch_rd[i];
        end
    end

endmodule

// File: rtl/dtimer_checker.sv
module dtimer_checker
    import dtimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                              clk,
    input logic                              rst,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic                              bus_we,
    input logic [DATA_W-1:0]                 bus_rdata,
    input logic [NUM_TIMERS-1:0]             irq,
    input logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt,
    input logic [NUM_TIMERS-1:0][DATA_W-1:0] ld,
    input logic [NUM_TIMERS-1:0]             run,
    input logic [NUM_TIMERS-1:0]             raw,
    input logic [NUM_TIMERS-1:0]             oneshot
);

    assert_out_of_range_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(WINDOW_WORDS)) |-> (bus_rdata == '0));

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_t
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * BANK_WORDS);
        logic touched;
        assign touched = bus_we && (bus_addr >= BASE) && (bus_addr < BASE + ADDR_W'(BANK_WORDS));

        assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
            (run[i] && cnt[i] != '0 && !touched) |=> (cnt[i] == $past(cnt[i]) - DATA_W'(1)));

        assert_expiry_flag_R5: assert property (@(posedge clk) disable iff (rst)
            (run[i] && cnt[i] == '0) |=> raw[i]);

        assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (rst)
            (run[i] && cnt[i] == '0 && !oneshot[i] && !touched) |=> (run[i] && cnt[i] == $past(ld[i])));

        assert_oneshot_halt_R6: assert property (@(posedge clk) disable iff (rst)
            (run[i] && cnt[i] == '0 && oneshot[i] && !touched) |=> (!run[i] && cnt[i] == '0));

        assert_masked_view_R10: assert property (@(posedge clk) disable iff (rst)
            (bus_addr == BASE + ADDR_W'(5)) |-> (bus_rdata == DATA_W'(irq[i])));

        assert_value_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == BASE && !run[i]) |=> (cnt[i] == $past(cnt[i])));
    end

endmodule

bind dual_down_timer dtimer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cnt       (ch_count),
    .ld        (ch_load),
    .run       (ch_run),
    .raw       (ch_raw),
    .oneshot   (ch_oneshot)
);

// File: tb/dual_down_timer_tb.sv
`timescale 1ns/1ps
module dual_down_timer_tb;

    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [1:0]    irq;

    int  compared = 0;
    int  mismatched = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    dual_down_timer #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // behavioural reference model
    logic [DW-1:0] m_cnt [2];
    logic [DW-1:0] m_load[2];
    logic [DW-1:0] m_bg  [2];
    logic [2:0]    m_ctrl[2];
    logic          m_raw [2];
    logic          m_run [2];

    always @(posedge clk) begin
        for (int t = 0; t < 2; t++) begin
            logic [DW-1:0] n_cnt, n_load, n_bg;
            logic [2:0]    n_ctrl;
            logic          n_raw, n_run, hit;
            int            a, o;
            if (rst) begin
                m_cnt[t] = 0; m_load[t] = 0; m_bg[t] = 0;
                m_ctrl[t] = 0; m_raw[t] = 0; m_run[t] = 0;
            end else begin
                n_cnt = m_cnt[t]; n_load = m_load[t]; n_bg = m_bg[t];
                n_ctrl = m_ctrl[t]; n_raw = m_raw[t]; n_run = m_run[t];
                hit = m_run[t] && m_cnt[t] == 0;
                if (m_run[t]) begin
                    if (hit) begin
                        if (m_ctrl[t][1]) n_run = 0;
                        else n_cnt = m_load[t];
                    end else n_cnt = m_cnt[t] - 1;
                end
                a = int'(bus_addr);
                o = a - 6 * t;
                if (bus_we && o >= 0 && o < 6) begin
                    if (o == 4 && bus_wdata[0]) n_raw = 0;
                    if (o == 3) begin
                        n_ctrl = bus_wdata[2:0];
                        if (bus_wdata[0]) begin n_cnt = m_load[t]; n_run = 1; end
                        else n_run = 0;
                    end
                    if (o == 1) begin
                        n_load = bus_wdata;
                        if (m_ctrl[t][0]) begin n_cnt = bus_wdata; n_run = 1; end
                    end
                    if (o == 2) begin n_bg = bus_wdata; n_load = bus_wdata; end
                end
                if (hit) n_raw = 1;
                m_cnt[t] = n_cnt; m_load[t] = n_load; m_bg[t] = n_bg;
                m_ctrl[t] = n_ctrl; m_raw[t] = n_raw; m_run[t] = n_run;
            end
        end
    end

    function automatic logic [DW-1:0] exp_rd(input int a);
        int t, o;
        if (a >= 12) return '0;
        t = a / 6;
        o = a % 6;
        case (o)
            0: return m_cnt[t];
            1: return m_load[t];
            2: return m_bg[t];
            3: return DW'(m_ctrl[t]);
            4: return DW'(m_raw[t]);
            default: return DW'(m_raw[t] & m_ctrl[t][2]);
        endcase
    endfunction

    function automatic string tag_of(input int a);
        if (a >= 12) return "R2";
        case (a % 6)
            0: return "R4";
            1: return "R7";
            2: return "R8";
            3: return "R3";
            4: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", tag, bus_addr, act, expv, $time);
        end
    endtask

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tag_of(int'(bus_addr)), bus_rdata, exp_rd(int'(bus_addr)));
            chk("R10", DW'(irq[0]), DW'(m_raw[0] & m_ctrl[0][2]));
            chk("R10", DW'(irq[1]), DW'(m_raw[1] & m_ctrl[1][2]));
        end
    end

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(posedge clk); #2;
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic dchk(input int a, input string tag);
        @(posedge clk); #2;
        bus_addr = AW'(a);
        @(negedge clk); #1;
        chk(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic sweep();
        for (int a = 0; a < 16; a++) begin
            @(posedge clk); #2;
            bus_addr = AW'(a);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1: every register and both irq bits clear after reset
        for (int a = 0; a < 12; a++) dchk(a, "R1");
        chk("R1", DW'(irq), '0);

        wr(1, 5);                       // R7: disabled, store only
        dchk(0, "R7");
        dchk(1, "R7");
        wr(3, 5);                       // enable + interrupt enable, periodic
        dchk(0, "R3");
        idle(2);
        dchk(0, "R4");
        idle(10);
        dchk(4, "R5");
        dchk(5, "R10");
        wr(4, 0);                       // R9: zero write leaves flag
        dchk(4, "R9");
        wr(4, 1);
        dchk(4, "R9");
        wr(2, 3);                       // R8: background write keeps count
        dchk(0, "R8");
        dchk(1, "R8");
        dchk(2, "R8");
        idle(12);
        sweep();
        wr(1, 9);                       // R7: enabled, reload now
        dchk(0, "R7");

        wr(7, 4);                       // timer 1 one-shot, no interrupt enable
        wr(9, 3);
        dchk(0, "R12");
        idle(10);
        dchk(6, "R6");
        dchk(10, "R6");
        dchk(11, "R10");
        wr(9, 6);                       // interrupt enable, stopped
        dchk(11, "R10");
        dchk(6, "R6");

        wr(6, 32'h55);                  // R11: count word ignores writes
        dchk(6, "R11");
        wr(11, 0);
        dchk(10, "R11");
        wr(13, 1234);                   // R2: beyond window
        dchk(13, "R2");
        sweep();

        wr(3, 0);                       // stop timer 0
        idle(5);
        dchk(0, "R3");
        wr(8, 7);                       // timer 1 periodic with staged period
        wr(9, 1);
        dchk(0, "R12");
        idle(30);
        sweep();
        wr(3, 1);
        idle(25);
        sweep();
        wr(1, 0);                       // zero load: expiry every clock
        idle(5);
        wr(4, 1);                       // R9: expiry beats clear
        dchk(4, "R9");
        wr(3, 7);                       // one-shot restart from zero load
        idle(4);
        dchk(0, "R6");
        dchk(4, "R5");
        sweep();

        done = 1;
        finish_run();
    end

endmodule